// File: doc/BRIEF.md
# Queued One-Hot Statechart Engine

This block runs a flat statechart in hardware. Every state owns one flip-flop, and exactly one of them is set at any time. The transitions are fixed when the block is elaborated. Each transition is described by four parameter arrays: the state it leaves, the state it enters, an event code, and a kind. The kind says whether the transition fires on a specific event code, on any code the state does not list explicitly (wildcard), or with no event at all (eventless).

Event codes are strobed in from outside and held in a circular queue until the engine can use them. On each enabled clock the engine does one of two things. If an active state has an eventless transition, that transition fires and the queue is left alone. Otherwise the engine takes the oldest queued event and matches it against the active state's transitions. Deasserting the enable freezes the state and the queue's read side, but events can still be pushed in.

A completion output shows when a state marked as final is active. A registered error output shows that the queue is full.

Top module: `sc_engine`

## Requirements
- R1: After synchronous reset the state vector is the one-hot code of the INITIAL state (bit i stands for state i), the error output is 0 and the queue is empty.
- R2: With enable high, an event strobed in on clock edge k is offered on the next cycle. If it matches, the state vector shows the target state after edge k+1. One event is consumed per enabled clock. With no event and no eventless transition, the state does not change.
- R3: When several transitions of the active state match the same event, the one with the lowest table index fires.
- R4: A wildcard transition fires for any event code that the active state does not list on one of its own explicit transitions, including codes that other states do list.
- R5: An event that matches nothing in the active state is consumed and leaves the state unchanged.
- R6: While an active state has an eventless transition, that transition fires on the next enabled clock, event transitions are held off, and no event is read from the queue.
- R7: While enable is low, the state vector holds and no event is consumed. Events strobed in meanwhile are queued and are processed once enable returns.
- R8: The queue holds QUEUE_DEPTH events. A push while it is full is dropped. The error output goes to 1 one clock after the queue becomes full and falls one clock after the queue stops being full.
- R9: The completed output is 1 exactly while a state whose FINAL_MASK bit is set is active.
- R10: The state vector always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run enable; low stalls the engine |
| ev_code | input | EVENT_W | Event code to queue |
| ev_push | input | 1 | Strobe that queues ev_code on this edge |
| active_o | output | N_STATES | One-hot current state vector |
| overflow_err_o | output | 1 | Registered queue-full error |
| done_o | output | 1 | A final state is active |

## Verification
The default chart is driven through several kinds of input:

- Explicitly matched codes separate a correct next-state network from one that routes to the wrong target.
- A code that two transitions of one state both claim shows whether the lower table index wins.
- Unlisted codes, and codes listed only in other states, separate wildcard matching from plain matching and from dropping the event.
- Two events pushed back to back into a state with an eventless exit show whether the queue read is suppressed. If the read were not suppressed, the second event would be lost in the intermediate state.
- A stalled burst that fills the queue, followed by one extra code that would otherwise move the state, shows that the overflowing write is dropped and that the error output rises and falls on time.

// File: rtl/sc_pkg.sv
package sc_pkg;

    // How a table entry is triggered
    typedef enum logic [1:0] {
        TK_EVENT = 2'd0,   // fires on its own event code
        TK_ANY   = 2'd1,   // fires on a code its source state does not list
        TK_AUTO  = 2'd2    // fires without an event, ahead of the queue
    } tr_kind_e;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sc_event_queue.sv
module sc_event_queue #(
    parameter int DEPTH = 256,
    parameter int EW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [EW-1:0] din,
    output logic [EW-1:0] dout,
    output logic          empty,
    output logic          full
);
    localparam int AW = sc_pkg::idx_w(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q, wr_n, rd_n;
    logic          lap_q, lap_n;
    logic          pop_ok, push_ok;

    always_comb begin
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        wr_n    = wr_q;
        rd_n    = rd_q;
        lap_n   = lap_q;
        if (pop_ok) begin
            if (rd_q == LAST) begin
                rd_n  = '0;
                lap_n = 1'b0;
            end else begin
                rd_n = rd_q + 1'b1;
            end
        end
        if (push_ok) begin
            if (wr_q == LAST) begin
                wr_n  = '0;
                lap_n = 1'b1;
            end else begin
                wr_n = wr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            lap_q <= 1'b0;
            empty <= 1'b1;
            full  <= 1'b0;
        end else begin
            wr_q  <= wr_n;
            rd_q  <= rd_n;
            lap_q <= lap_n;
            empty <= (wr_n == rd_n) && !lap_n;
            full  <= (wr_n == rd_n) && lap_n;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_q] <= din;
    end

    assign dout = mem[rd_q];

endmodule

// File: rtl/sc_fire_select.sv
module sc_fire_select #(
    parameter int N_STATES = 4,
    parameter int N_TRANS  = 7,
    parameter int EW       = 3,
    parameter int TR_SRC [N_TRANS] = '{0, 0, 1, 2, 2, 3, 0},
    parameter int TR_EVT [N_TRANS] = '{1, 2, 0, 3, 0, 1, 1},
    parameter sc_pkg::tr_kind_e TR_KIND [N_TRANS] = '{
        sc_pkg::TK_EVENT, sc_pkg::TK_EVENT, sc_pkg::TK_AUTO, sc_pkg::TK_EVENT,
        sc_pkg::TK_ANY, sc_pkg::TK_EVENT, sc_pkg::TK_EVENT}
) (
    input  logic [N_STATES-1:0] cur,
    input  logic                ev_avail,
    input  logic [EW-1:0]       ev_code,
    output logic [N_TRANS-1:0]  fire,
    output logic                spont
);
    logic [N_TRANS-1:0]  auto_hit, cand;
    logic [N_STATES-1:0] listed, taken;

    always_comb begin
        auto_hit = '0;
        cand     = '0;
        listed   = '0;
        taken    = '0;
        fire     = '0;
        for (int t = 0; t < N_TRANS; t++) begin
            auto_hit[t] = (TR_KIND[t] == sc_pkg::TK_AUTO) && cur[TR_SRC[t]];
            if (TR_KIND[t] == sc_pkg::TK_EVENT && ev_code == EW'(TR_EVT[t]))
                listed[TR_SRC[t]] = 1'b1;
        end
        spont = |auto_hit;
        for (int t = 0; t < N_TRANS; t++) begin
            unique case (TR_KIND[t])
                sc_pkg::TK_AUTO:  cand[t] = auto_hit[t];
                sc_pkg::TK_EVENT: cand[t] = !spont && ev_avail && cur[TR_SRC[t]]
                                            && ev_code == EW'(TR_EVT[t]);
                sc_pkg::TK_ANY:   cand[t] = !spont && ev_avail && cur[TR_SRC[t]]
                                            && !listed[TR_SRC[t]];
                default:          cand[t] = 1'b0;
            endcase
        end
        // lowest table index wins within each source state
        for (int t = 0; t < N_TRANS; t++) begin
            fire[t] = cand[t] && !taken[TR_SRC[t]];
            if (cand[t]) taken[TR_SRC[t]] = 1'b1;
        end
    end

endmodule

// File: rtl/sc_next_state.sv
module sc_next_state #(
    parameter int N_STATES = 4,
    parameter int N_TRANS  = 7,
    parameter int TR_SRC [N_TRANS] = '{0, 0, 1, 2, 2, 3, 0},
    parameter int TR_DST [N_TRANS] = '{1, 2, 2, 3, 0, 0, 3}
) (
    input  logic [N_STATES-1:0] cur,
    input  logic [N_TRANS-1:0]  fire,
    output logic [N_STATES-1:0] nxt
);
    for (genvar s = 0; s < N_STATES; s++) begin : g_bit
        logic enter, leave;
        always_comb begin
            enter = 1'b0;
            leave = 1'b0;
            for (int t = 0; t < N_TRANS; t++) begin
                if (TR_DST[t] == s) enter = enter | fire[t];
                if (TR_SRC[t] == s) leave = leave | fire[t];
            end
            nxt[s] = enter | (cur[s] & ~leave);
        end
    end

endmodule

// File: rtl/sc_engine.sv
module sc_engine #(
    parameter int N_STATES    = 4,
    parameter int EVENT_W     = 3,
    parameter int QUEUE_DEPTH = 256,
    parameter int INITIAL     = 0,
    parameter logic [N_STATES-1:0] FINAL_MASK = N_STATES'(8),
    parameter int N_TRANS     = 7,
    parameter int TR_SRC [N_TRANS] = '{0, 0, 1, 2, 2, 3, 0},
    parameter int TR_DST [N_TRANS] = '{1, 2, 2, 3, 0, 0, 3},
    parameter int TR_EVT [N_TRANS] = '{1, 2, 0, 3, 0, 1, 1},
    parameter sc_pkg::tr_kind_e TR_KIND [N_TRANS] = '{
        sc_pkg::TK_EVENT, sc_pkg::TK_EVENT, sc_pkg::TK_AUTO, sc_pkg::TK_EVENT,
        sc_pkg::TK_ANY, sc_pkg::TK_EVENT, sc_pkg::TK_EVENT}
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic [EVENT_W-1:0]  ev_code,
    input  logic                ev_push,
    output logic [N_STATES-1:0] active_o,
    output logic                overflow_err_o,
    output logic                done_o
);
    localparam logic [N_STATES-1:0] INIT_VEC = N_STATES'(1) << INITIAL;

    logic [N_STATES-1:0] state_q, state_n;
    logic [N_TRANS-1:0]  fire;
    logic [EVENT_W-1:0]  q_head;
    logic                q_empty, q_full, q_pop, ev_avail, spont;
    logic                err_q;

    assign ev_avail = enable && !q_empty;
    assign q_pop    = ev_avail && !spont;

    sc_event_queue #(.DEPTH(QUEUE_DEPTH), .EW(EVENT_W)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (ev_push),
        .pop   (q_pop),
        .din   (ev_code),
        .dout  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    sc_fire_select #(
        .N_STATES(N_STATES), .N_TRANS(N_TRANS), .EW(EVENT_W),
        .TR_SRC(TR_SRC), .TR_EVT(TR_EVT), .TR_KIND(TR_KIND)
    ) u_select (
        .cur      (state_q),
        .ev_avail (ev_avail),
        .ev_code  (q_head),
        .fire     (fire),
        .spont    (spont)
    );

    sc_next_state #(
        .N_STATES(N_STATES), .N_TRANS(N_TRANS),
        .TR_SRC(TR_SRC), .TR_DST(TR_DST)
    ) u_next (
        .cur  (state_q),
        .fire (fire),
        .nxt  (state_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= INIT_VEC;
            err_q   <= 1'b0;
        end else begin
            if (enable) state_q <= state_n;
            err_q <= q_full;
        end
    end

    assign active_o       = state_q;
    assign overflow_err_o = err_q;
    assign done_o         = |(state_q & FINAL_MASK);

endmodule

// File: rtl/sc_engine_checker.sv
module sc_engine_checker #(
    parameter int N_STATES = 4,
    parameter int INITIAL  = 0
) (
    input logic                clk,
    input logic                rst,
    input logic                enable,
    input logic [N_STATES-1:0] state,
    input logic                q_full,
    input logic                q_empty,
    input logic                q_pop,
    input logic                spont
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> state == (N_STATES'(1) << INITIAL));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (enable && !spont && q_empty) |=> $stable(state));

    assert_auto_blocks_read_R6: assert property (@(posedge clk) disable iff (rst)
        spont |-> !q_pop);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(state));

    assert_stall_no_read_R7: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !q_pop);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (q_full && !q_pop) |=> q_full);

    assert_one_hot_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(state) == 1);

endmodule

bind sc_engine sc_engine_checker #(.N_STATES(N_STATES), .INITIAL(INITIAL)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .state   (state_q),
    .q_full  (q_full),
    .q_empty (q_empty),
    .q_pop   (q_pop),
    .spont   (spont)
);

// File: tb/sc_engine_tb.sv
module sc_engine_tb;
    localparam int DEPTH = 256;
    localparam logic [3:0] S0 = 4'b0001, S1 = 4'b0010, S2 = 4'b0100, S3 = 4'b1000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b1;
    logic [2:0] ev_code = '0;
    logic       ev_push = 1'b0;
    logic [3:0] active_o;
    logic       overflow_err_o, done_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sc_engine u_dut (
        .clk(clk), .rst(rst), .enable(enable), .ev_code(ev_code), .ev_push(ev_push),
        .active_o(active_o), .overflow_err_o(overflow_err_o), .done_o(done_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // queue one code; returns at the falling edge after the capturing edge
    task automatic push(input logic [2:0] code);
        @(negedge clk);
        ev_code = code;
        ev_push = 1'b1;
        @(negedge clk);
        ev_push = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(active_o, S0, "R1 state");
        chk(overflow_err_o, 0, "R1 error");
        chk(done_o, 0, "R9 done low");
        idle(3);
        chk(active_o, S0, "R2 no event no change");
    endtask

    task automatic t_basic;
        push(3'd1);
        idle(1);
        chk(active_o, S1, "R3 lowest index wins on code 1");
        idle(1);
        chk(active_o, S2, "R6 eventless exit");
        push(3'd3);
        idle(1);
        chk(active_o, S3, "R2 code 3 to final");
        chk(done_o, 1, "R9 done high");
        push(3'd1);
        idle(1);
        chk(active_o, S0, "R2 code 1 leaves final");
        chk(done_o, 0, "R9 done low again");
    endtask

    task automatic t_wildcard;
        push(3'd2);
        idle(1);
        chk(active_o, S2, "R2 code 2");
        push(3'd5);
        idle(1);
        chk(active_o, S0, "R4 unlisted code 5");
        push(3'd1);
        idle(2);
        chk(active_o, S2, "R4 setup");
        push(3'd1);
        idle(1);
        chk(active_o, S0, "R4 code listed only elsewhere");
    endtask

    task automatic t_unmatched;
        push(3'd4);
        idle(1);
        chk(active_o, S0, "R5 unmatched code");
        idle(2);
        chk(active_o, S0, "R5 still held");
        push(3'd2);
        idle(1);
        chk(active_o, S2, "R5 unmatched code was consumed");
        push(3'd6);
        idle(1);
        chk(active_o, S0, "R4 return");
    endtask

    task automatic t_auto_priority;
        @(negedge clk);
        ev_code = 3'd1; ev_push = 1'b1;
        @(negedge clk);
        ev_code = 3'd2;
        @(negedge clk);
        ev_push = 1'b0;
        chk(active_o, S1, "R6 first code taken");
        idle(1);
        chk(active_o, S2, "R6 eventless fires before queued code");
        idle(1);
        chk(active_o, S0, "R6 queued code kept for next state");
    endtask

    task automatic t_stall;
        @(negedge clk);
        enable = 1'b0;
        push(3'd1);
        idle(4);
        chk(active_o, S0, "R7 stalled state holds");
        enable = 1'b1;
        idle(1);
        chk(active_o, S1, "R7 queued code runs after stall");
        idle(1);
        chk(active_o, S2, "R7 eventless after stall");
        push(3'd7);
        idle(1);
        chk(active_o, S0, "R4 return");
    endtask

    task automatic t_overflow;
        @(negedge clk);
        enable = 1'b0;
        ev_code = 3'd4;
        ev_push = 1'b1;
        for (int i = 0; i < DEPTH; i++) @(negedge clk);
        chk(overflow_err_o, 0, "R8 error lags full by one clock");
        ev_code = 3'd1;
        @(negedge clk);
        ev_push = 1'b0;
        chk(overflow_err_o, 1, "R8 error after full");
        chk(active_o, S0, "R7 held while filling");
        enable = 1'b1;
        idle(1);
        chk(overflow_err_o, 1, "R8 error one clock after first read");
        idle(1);
        chk(overflow_err_o, 0, "R8 error clears");
        idle(DEPTH + 20);
        chk(active_o, S0, "R8 overflowing code 1 dropped");
        push(3'd1);
        idle(1);
        chk(active_o, S1, "R8 queue usable after drain");
        idle(1);
        push(3'd0);
        idle(1);
        chk(active_o, S0, "R4 code 0 wildcard");
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wildcard();
        t_unmatched();
        t_auto_priority();
        t_stall();
        t_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule